// File: doc/BRIEF.md
# Auto-Ranging High-Resolution Measurement Sequencer

This block is the control state machine that sits in front of a gated counter core and turns two raw measurements into one high-resolution reading. On a start request it runs a short frequency-mode measurement. It scales that count by ten to get a coarse frequency, then picks the follow-up measurement. At or above the reference frequency it runs a long frequency-mode gate. Below it, it runs a period-mode measurement whose gate preset equals the coarse frequency, so the gate stays open for close to one second of reference time.

The block also recovers the count bank's lost overflows. The expected full-window count of the long frequency measurement is the coarse frequency itself. Its bits above the counter width give the number of times the 24-bit bank wrapped, so no wider counter and no divider are needed. The block reports the raw final count, the gate preset used, the chosen mode and the wrap count. The final ratio arithmetic is left to the consumer. A zero coarse count ends the sequence early with a no-signal flag. A period-mode gate that never closes is cut off by a watchdog and flagged as a timeout.

Top module: `hires_sequencer`

## Requirements
- R1: While rst is high and right after it, core_load, core_start, res_valid and busy are all 0.
- R2: A go pulse in idle gives exactly one core_load cycle with core_mode=0 (frequency) and core_gate=COARSE_GATE. core_start follows for exactly one cycle in the next cycle.
- R3: The coarse frequency is the coarse count times 10. If it is at least REF_HZ, the second load uses core_mode=0 and core_gate=FINE_GATE, and res_mode is 0.
- R4: If the coarse frequency is below REF_HZ and nonzero, the second load uses core_mode=1 (period) and core_gate equals the coarse frequency, and res_mode is 1.
- R5: res_wraps is floor(coarse frequency / 2^24) in frequency mode and 0 in period mode.
- R6: The cycle after core_done is seen in the second wait, res_valid is high for exactly one cycle. res_count then holds the second count and res_gate holds the gate preset that was used.
- R7: A coarse count of 0 skips the second load. The result then has res_nosig=1 and res_count, res_gate, res_mode and res_wraps all 0, and it is reported two cycles after the coarse core_done.
- R8: In period mode, if core_done does not arrive within TIMEOUT_CYC cycles of the second wait, the result is reported with res_timeout=1 and res_count=0.
- R9: go is ignored while busy is 1; it causes no extra load or start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start a sequence (taken only when idle) |
| core_done | input | 1 | Counter core finished its gate |
| core_count | input | CW | Count bank value from the core |
| core_load | output | 1 | Preload pulse to the core |
| core_start | output | 1 | Start pulse to the core |
| core_mode | output | 1 | 0 frequency, 1 period |
| core_gate | output | CW | Gate counter preset |
| busy | output | 1 | Sequence in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_count | output | CW | Raw second count |
| res_gate | output | CW | Gate preset used |
| res_mode | output | 1 | Mode chosen for the second measurement |
| res_wraps | output | WRAP_W | Recovered wrap count |
| res_nosig | output | 1 | Coarse count was zero |
| res_timeout | output | 1 | Period gate did not close in time |

## Verification
A low coarse count (99) shows the period branch with a small gate preset. A 6,000,000 count tells the frequency branch apart and checks a three-wrap recovery. The counts 1,000,000 and 999,999 sit on either side of the 10 MHz threshold, and 1,677,721 and 1,677,722 sit on either side of the first wrap. A zero coarse count, a period gate that never closes and a go pulse sent mid-run cover the no-signal exit, the watchdog and the busy lockout.

// File: rtl/hires_seq_pkg.sv
package hires_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CLOAD,
    S_CWAIT,
    S_DECIDE,
    S_FLOAD,
    S_FWAIT,
    S_DONE
  } seq_state_t;

  localparam logic MODE_FREQ   = 1'b0;
  localparam logic MODE_PERIOD = 1'b1;
endpackage

// File: rtl/hires_range_eval.sv
module hires_range_eval #(
  parameter int CW     = 24,
  parameter int WRAP_W = 4,
  parameter int REF_HZ = 10_000_000
) (
  input  logic [CW-1:0]     coarse,
  output logic [CW-1:0]     freq_low,
  output logic [WRAP_W-1:0] wraps,
  output logic              at_or_above,
  output logic              is_zero
);
  localparam int FW = CW + WRAP_W;

  logic [FW-1:0] wide;
  logic [FW-1:0] freq;

  always_comb begin
    wide        = {{WRAP_W{1'b0}}, coarse};
    freq        = (wide << 3) + (wide << 1);
    freq_low    = freq[CW-1:0];
    wraps       = freq[FW-1:CW];
    at_or_above = (freq >= FW'(REF_HZ));
    is_zero     = (coarse == '0);
  end
endmodule

// File: rtl/hires_watchdog.sv
module hires_watchdog #(
  parameter int LIMIT = 400_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic expire
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  assign expire = en && (cnt == TW'(LIMIT - 1));
endmodule

// File: rtl/hires_sequencer.sv
module hires_sequencer
  import hires_seq_pkg::*;
#(
  parameter int CW          = 24,
  parameter int WRAP_W      = 4,
  parameter int REF_HZ      = 10_000_000,
  parameter int COARSE_GATE = 1_000_000,
  parameter int FINE_GATE   = 10_000_000,
  parameter int TIMEOUT_CYC = 400_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              core_done,
  input  logic [CW-1:0]     core_count,
  output logic              core_load,
  output logic              core_start,
  output logic              core_mode,
  output logic [CW-1:0]     core_gate,
  output logic              busy,
  output logic              res_valid,
  output logic [CW-1:0]     res_count,
  output logic [CW-1:0]     res_gate,
  output logic              res_mode,
  output logic [WRAP_W-1:0] res_wraps,
  output logic              res_nosig,
  output logic              res_timeout
);
  seq_state_t        state_q, state_d;
  logic [CW-1:0]     coarse_q;
  logic [CW-1:0]     freq_low;
  logic [WRAP_W-1:0] wraps_now, wraps_q;
  logic              above, zero, expire;

  hires_range_eval #(.CW(CW), .WRAP_W(WRAP_W), .REF_HZ(REF_HZ)) u_eval (
    .coarse      (coarse_q),
    .freq_low    (freq_low),
    .wraps       (wraps_now),
    .at_or_above (above),
    .is_zero     (zero)
  );

  hires_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .en     ((state_q == S_FWAIT) && (core_mode == MODE_PERIOD)),
    .expire (expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (go) state_d = S_CLOAD;
      S_CLOAD:  state_d = S_CWAIT;
      S_CWAIT:  if (core_done) state_d = S_DECIDE;
      S_DECIDE: state_d = zero ? S_DONE : S_FLOAD;
      S_FLOAD:  state_d = S_FWAIT;
      S_FWAIT:  if (core_done || expire) state_d = S_DONE;
      S_DONE:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      coarse_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_CWAIT && core_done) coarse_q <= core_count;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_load   <= 1'b0;
      core_start  <= 1'b0;
      core_mode   <= MODE_FREQ;
      core_gate   <= '0;
      wraps_q     <= '0;
      busy        <= 1'b0;
      res_valid   <= 1'b0;
      res_count   <= '0;
      res_gate    <= '0;
      res_mode    <= MODE_FREQ;
      res_wraps   <= '0;
      res_nosig   <= 1'b0;
      res_timeout <= 1'b0;
    end else begin
      core_load  <= (state_d == S_CLOAD) || (state_d == S_FLOAD);
      core_start <= (state_q == S_CLOAD) || (state_q == S_FLOAD);
      busy       <= (state_d != S_IDLE);
      res_valid  <= (state_d == S_DONE);

      if (state_d == S_CLOAD) begin
        core_mode <= MODE_FREQ;
        core_gate <= CW'(COARSE_GATE);
      end
      if (state_d == S_FLOAD) begin
        core_mode <= above ? MODE_FREQ : MODE_PERIOD;
        core_gate <= above ? CW'(FINE_GATE) : freq_low;
        wraps_q   <= above ? wraps_now : '0;
      end

      if (state_q == S_DECIDE && zero) begin
        res_count   <= '0;
        res_gate    <= '0;
        res_mode    <= MODE_FREQ;
        res_wraps   <= '0;
        res_nosig   <= 1'b1;
        res_timeout <= 1'b0;
      end
      if (state_q == S_FWAIT && state_d == S_DONE) begin
        res_count   <= core_done ? core_count : '0;
        res_gate    <= core_gate;
        res_mode    <= core_mode;
        res_wraps   <= wraps_q;
        res_nosig   <= 1'b0;
        res_timeout <= !core_done;
      end
    end
  end
endmodule

// File: rtl/hires_sequencer_chk.sv
module hires_sequencer_chk #(
  parameter int CW     = 24,
  parameter int WRAP_W = 4,
  parameter int REF_HZ = 10_000_000
) (
  input logic              clk,
  input logic              rst,
  input logic              go,
  input logic              core_load,
  input logic              core_start,
  input logic              core_mode,
  input logic [CW-1:0]     core_gate,
  input logic              busy,
  input logic              res_valid,
  input logic [CW-1:0]     res_count,
  input logic              res_mode,
  input logic [WRAP_W-1:0] res_wraps,
  input logic              res_nosig,
  input logic              res_timeout
);
  assert_start_after_load_R2: assert property (@(posedge clk) disable iff (rst)
    core_load |=> (core_start && !core_load));

  assert_period_gate_below_ref_R4: assert property (@(posedge clk) disable iff (rst)
    (core_load && core_mode) |-> (core_gate < CW'(REF_HZ)));

  assert_period_no_wraps_R5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_mode) |-> (res_wraps == '0));

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_nosig_clean_R7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_nosig) |-> (res_count == '0 && !res_timeout && !res_mode));

  assert_timeout_period_only_R8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_timeout) |-> (res_mode && res_count == '0));

  assert_idle_go_loads_R9: assert property (@(posedge clk) disable iff (rst)
    (go && busy) |=> !core_load || $past(core_load) || busy);

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && !go) |=> !core_load);
endmodule

bind hires_sequencer hires_sequencer_chk #(.CW(CW), .WRAP_W(WRAP_W), .REF_HZ(REF_HZ)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .go          (go),
  .core_load   (core_load),
  .core_start  (core_start),
  .core_mode   (core_mode),
  .core_gate   (core_gate),
  .busy        (busy),
  .res_valid   (res_valid),
  .res_count   (res_count),
  .res_mode    (res_mode),
  .res_wraps   (res_wraps),
  .res_nosig   (res_nosig),
  .res_timeout (res_timeout)
);

// File: tb/hires_sequencer_tb.sv
module hires_sequencer_tb;
  localparam int CW = 24, WRAP_W = 4, REF_HZ = 10_000_000;
  localparam int CGATE = 1_000_000, FGATE = 10_000_000, TMO = 40;

  logic clk = 1'b0, rst = 1'b1, go = 1'b0, done_i = 1'b0;
  logic [CW-1:0] cnt_i = '0;
  logic core_load, core_start, core_mode, busy, res_valid, res_mode, res_nosig, res_timeout;
  logic [CW-1:0] core_gate, res_count, res_gate;
  logic [WRAP_W-1:0] res_wraps;

  always #2.5 clk = ~clk;

  hires_sequencer #(.CW(CW), .WRAP_W(WRAP_W), .REF_HZ(REF_HZ), .COARSE_GATE(CGATE),
                    .FINE_GATE(FGATE), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst(rst), .go(go), .core_done(done_i), .core_count(cnt_i),
    .core_load(core_load), .core_start(core_start), .core_mode(core_mode), .core_gate(core_gate),
    .busy(busy), .res_valid(res_valid), .res_count(res_count), .res_gate(res_gate),
    .res_mode(res_mode), .res_wraps(res_wraps), .res_nosig(res_nosig), .res_timeout(res_timeout));

  int checks = 0, failures = 0, cyc = 0;
  bit seen_edge = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: 0 idle 1 cload 2 cwait 3 decide 4 fload 5 fwait 6 done
  int m_ph = 0, m_prev = 0, m_tw = 0;
  longint m_coarse, m_f, m_gate, m_cnt, m_wraps;
  bit m_pmode, m_nosig, m_tmo;

  always @(posedge clk) begin
    seen_edge = 1;
    cyc++;
    m_prev = m_ph;
    if (rst) m_ph = 0;
    else begin
      case (m_ph)
        0: if (go) m_ph = 1;
        1: m_ph = 2;
        2: if (done_i) begin m_coarse = cnt_i; m_ph = 3; end
        3: begin
          m_f = m_coarse * 10;
          if (m_coarse == 0) begin
            m_nosig = 1; m_tmo = 0; m_cnt = 0; m_gate = 0; m_pmode = 0; m_wraps = 0; m_ph = 6;
          end else begin
            m_pmode = (m_f < REF_HZ);
            m_gate  = m_pmode ? m_f : FGATE;
            m_wraps = m_pmode ? 0 : m_f / 16777216;
            m_ph = 4;
          end
        end
        4: begin m_ph = 5; m_tw = 0; end
        5: begin
          if (done_i) begin
            m_cnt = cnt_i; m_nosig = 0; m_tmo = 0; m_ph = 6;
          end else if (m_pmode) begin
            m_tw++;
            if (m_tw == TMO) begin m_cnt = 0; m_nosig = 0; m_tmo = 1; m_ph = 6; end
          end
        end
        default: m_ph = 0;
      endcase
    end
  end

  // core model state
  int cdelay, fdelay, nstarts, left;
  longint cval, fval, pend_val;
  bit armed = 0;

  always @(negedge clk) begin
    if (seen_edge) begin
      string tg;
      tg = rst ? "R1" : "R2";
      chk({tg, " core_load"}, core_load, (m_ph == 1 || m_ph == 4));
      chk({tg, " core_start"}, core_start, (m_ph == 2 && m_prev == 1) || (m_ph == 5 && m_prev == 4));
      chk(rst ? "R1 busy" : "R9 busy", busy, m_ph != 0);
      chk(rst ? "R1 res_valid" : "R6 res_valid", res_valid, m_ph == 6);
      if (m_ph == 1) begin
        chk("R2 coarse mode", core_mode, 0);
        chk("R2 coarse gate", core_gate, CGATE);
      end
      if (m_ph == 4) begin
        chk(m_pmode ? "R4 fine mode" : "R3 fine mode", core_mode, m_pmode);
        chk(m_pmode ? "R4 fine gate" : "R3 fine gate", core_gate, m_gate);
      end
      if (m_ph == 6) begin
        chk("R6 res_count", res_count, m_cnt);
        chk("R6 res_gate", res_gate, m_gate);
        chk(m_pmode ? "R4 res_mode" : "R3 res_mode", res_mode, m_pmode);
        chk("R5 res_wraps", res_wraps, m_wraps);
        chk("R7 res_nosig", res_nosig, m_nosig);
        chk("R8 res_timeout", res_timeout, m_tmo);
      end
    end
    // counter core stand-in
    done_i = 1'b0;
    if (armed) begin
      if (left == 0) begin done_i = 1'b1; cnt_i = CW'(pend_val); armed = 0; end
      else left--;
    end
    if (core_start === 1'b1) begin
      nstarts++;
      left     = (nstarts == 1) ? cdelay : fdelay;
      pend_val = (nstarts == 1) ? cval : fval;
      armed    = (left >= 0);
    end
  end

  always @(posedge clk) begin
    if (cyc >= 100000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(longint cv, longint fv, int cd, int fd, bit busy_go);
    cval = cv; fval = fv; cdelay = cd; fdelay = fd; nstarts = 0; armed = 0;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    if (busy_go) begin
      repeat (2) @(negedge clk);
      go = 1'b1;   // R9: must be ignored mid-run
      @(negedge clk); go = 1'b0;
    end
    for (int i = 0; i < 300 && m_ph != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    run(99, 9978329, 5, 20, 0);        // R4 period branch
    run(6000000, 9668352, 3, 30, 1);   // R3 R5 three wraps, R9 go while busy
    run(1000000, 10000000, 2, 4, 0);   // R3 exactly at threshold
    run(999999, 9999990, 2, 4, 0);     // R4 just below threshold
    run(1677721, 777, 1, 2, 0);        // R5 just below one wrap
    run(1677722, 123, 1, 2, 0);        // R5 one wrap
    run(0, 0, 3, 0, 0);                // R7 no signal
    run(500, 0, 2, -1, 0);             // R8 period gate never closes
    run(250, 2500000, 1, 6, 0);        // R6 normal run after a timeout
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule